// File: doc/BRIEF.md
# Delayed Modular Reduction Scheduler

This block drives the operation stream into a deep arithmetic pipeline in order to bring a value `x`, held in a widened residue range, back into `[0, p)`. A comparison's outcome returns only after a fixed latency equal to the pipeline depth. Because of that latency, the scheduler does not wait on each outcome. It issues all four range tests back to back, one per cycle. It then fills the rest of the latency window with follow-on operations that consume `x`, and pads the remainder with NOPs.

The follow-on operations deliberately take the unreduced `x`. This is sound because the unreduced value and the reduced value lie in the same residue class modulo `p`.

As the tagged outcomes return in issue order, a resolver applies the first candidate that lands in range. It squashes every later conditional update. A cumulative stall counter records the NOP cycles, so the cost of the pipeline bubbles can be measured. The arithmetic pipeline is a fixed-latency stub. The operation that produces `x` is outside this block and is never placed into the window.

Top module: `redsched_top`

## Requirements
- R1: After reset, `busy` and `done` are 0, `stallCount` is 0, and `issueKind` is NONE (code 0).
- R2: A `start` pulse that is accepted in cycle s makes the block issue four comparisons on the next four cycles. These use kind code 1, with `issueTag` equal to 0, 1, 2, 3 in that order.
- R3: Comparison k tests the candidate `x - m*p`, where m is 0, 1, 2, -1 for k = 0, 1, 2, 3. The candidate passes when it lies in `[0, p)`. The lowest-tagged passing candidate becomes `resultX`, `reduceOk` goes to 1, and every later candidate is ignored.
- R4: After the comparisons, the block issues `min(depCount, LAT-4)` follow-on operations on consecutive cycles (kind code 2). Each carries the unreduced `x` on `issueOperand`.
- R5: The issue window lasts LAT cycles. The cycles left after the comparisons and follow-on operations carry NOP (kind code 3). After the window, the kind returns to NONE.
- R6: `stallCount` rises by exactly one for each NOP cycle and accumulates across reductions.
- R7: `done` is high for exactly one cycle, LAT+4 clock edges after the edge that accepted `start`. `busy` falls on that same edge.
- R8: When no candidate passes, `resultX` equals the input `x` and `reduceOk` is 0.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the issue stream nor the result.
- R10: `inX` and `depCount` are sampled on the accepting edge. `modP` must stay stable while `busy` is high, and whenever `reduceOk` is 1, `resultX` is congruent to `x` modulo `p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a reduction of `inX` (accepted when idle) |
| inX | input | W | Signed value to reduce, expected in `[-p, 3p)` |
| modP | input | W | Modulus p, positive, below 2^(W-3) |
| depCount | input | CW | Number of dependent follow-on operations available |
| busy | output | 1 | Reduction in progress |
| issueKind | output | 2 | Operation issued this cycle: 0 NONE, 1 CMP, 2 DEP, 3 NOP |
| issueTag | output | 2 | Comparison tag during CMP cycles, else 0 |
| issueOperand | output | W | Operand sent with the issued operation (unreduced x) |
| done | output | 1 | One-cycle pulse when the reduction resolves |
| resultX | output | W | Reduced value (valid at and after `done`) |
| reduceOk | output | 1 | 1 if some candidate fell in range |
| stallCount | output | SW | Cumulative count of NOP-filled cycles |

## Verification
Several internal faults show up in the issue stream within the first LAT cycles after `start`. A corrupted issue counter or a wrong follow-on limit shows as a wrong kind or tag in a specific cycle of that stream. It also shows as a `stallCount` that drifts by one or more by the end of the reduction.

A resolver that fails to squash later candidates, or that returns a tag out of order, shows in `resultX` on the `done` cycle, exactly LAT+4 edges after acceptance. The wrong value is then either outside `[0, p)` or not the lowest-offset candidate. A latch that tracks `inX` while busy shows the injected value on `issueOperand` during the follow-on cycles.

// File: rtl/redsched_pkg.sv
package redsched_pkg;
  localparam int NUM_CMP = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CMP  = 2'd1,
    OP_DEP  = 2'd2,
    OP_NOP  = 2'd3
  } opKind_e;

  typedef struct packed {
    logic       load;
    logic       cmpIssue;
    logic [1:0] cmpTag;
  } ctrlStrobe_t;

  // multiple of p subtracted by comparison k
  function automatic int candOffset(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/redsched_pipe.sv
// Fixed-latency stand-in for the arithmetic pipeline's comparison path.
module redsched_pipe #(
  parameter int LAT = 8,
  parameter int DW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  output logic          outValid,
  output logic [DW-1:0] outData
);
  logic          stageValid [LAT];
  logic [DW-1:0] stageData  [LAT];

  always_ff @(posedge clk) begin
    if (rst) stageValid[0] <= 1'b0;
    else     stageValid[0] <= inValid;
    stageData[0] <= inData;
  end

  for (genvar s = 1; s < LAT; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (rst) stageValid[s] <= 1'b0;
      else     stageValid[s] <= stageValid[s-1];
      stageData[s] <= stageData[s-1];
    end
  end

  assign outValid = stageValid[LAT-1];
  assign outData  = stageData[LAT-1];
endmodule

// File: rtl/redsched_ctrl.sv
module redsched_ctrl
  import redsched_pkg::*;
#(
  parameter int LAT = 8,
  parameter int CW  = 4,
  parameter int SW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] depCount,
  input  logic          retLast,
  output ctrlStrobe_t   strb,
  output logic          busy,
  output logic [1:0]    issueKind,
  output logic [1:0]    issueTag,
  output logic [SW-1:0] stallCount
);
  localparam int SLOT = LAT - NUM_CMP;
  localparam int CNTW = $clog2(LAT + 1);

  logic            inIssue;
  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   depLim;
  opKind_e         kind;

  always_comb begin
    if (!inIssue)                                   kind = OP_NONE;
    else if (int'(cnt) < NUM_CMP)                   kind = OP_CMP;
    else if (int'(cnt) < NUM_CMP + int'(depLim))    kind = OP_DEP;
    else                                            kind = OP_NOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      inIssue    <= 1'b0;
      cnt        <= '0;
      depLim     <= '0;
      stallCount <= '0;
    end else begin
      if (!busy && start) begin
        busy    <= 1'b1;
        inIssue <= 1'b1;
        cnt     <= '0;
        depLim  <= (int'(depCount) > SLOT) ? CW'(SLOT) : depCount;
      end else if (inIssue) begin
        cnt <= cnt + 1'b1;
        if (int'(cnt) == LAT - 1) inIssue <= 1'b0;
      end else if (busy && retLast) begin
        busy <= 1'b0;
      end
      if (kind == OP_NOP) stallCount <= stallCount + 1'b1;
    end
  end

  assign issueKind     = kind;
  assign issueTag      = (kind == OP_CMP) ? cnt[1:0] : 2'd0;
  assign strb.load     = !busy && start;
  assign strb.cmpIssue = (kind == OP_CMP);
  assign strb.cmpTag   = cnt[1:0];
endmodule

// File: rtl/redsched_data.sv
module redsched_data
  import redsched_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strb,
  input  logic signed [W-1:0] inX,
  input  logic        [W-1:0] modP,
  output logic signed [W-1:0] issueOperand,
  output logic                retLast,
  output logic                done,
  output logic signed [W-1:0] resultX,
  output logic                reduceOk
);
  logic signed [W-1:0] xHold;
  logic signed [W-1:0] pHold;
  logic signed [W-1:0] cand [NUM_CMP];
  logic                candHit [NUM_CMP];
  logic                resolved;

  for (genvar k = 0; k < NUM_CMP; k++) begin : gCand
    localparam int OFF = candOffset(k);
    always_comb begin
      cand[k]    = xHold - W'(OFF) * pHold;
      candHit[k] = (cand[k] >= 0) && (cand[k] < pHold);
    end
  end

  logic       retValid;
  logic [2:0] retData;
  logic [1:0] retTag;
  logic       retHit;

  redsched_pipe #(.LAT(LAT), .DW(3)) uPipe (
    .clk     (clk),
    .rst     (rst),
    .inValid (strb.cmpIssue),
    .inData  ({strb.cmpTag, candHit[strb.cmpTag]}),
    .outValid(retValid),
    .outData (retData)
  );

  assign retTag  = retData[2:1];
  assign retHit  = retData[0];
  assign retLast = retValid && (retTag == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      xHold    <= '0;
      pHold    <= '0;
      resultX  <= '0;
      reduceOk <= 1'b0;
      resolved <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= retLast;
      if (strb.load) begin
        xHold    <= inX;
        pHold    <= modP;
        resultX  <= inX;
        reduceOk <= 1'b0;
        resolved <= 1'b0;
      end else if (retValid && retHit && !resolved) begin
        resultX  <= cand[retTag];
        reduceOk <= 1'b1;
        resolved <= 1'b1;
      end
    end
  end

  assign issueOperand = xHold;
endmodule

// File: rtl/redsched_top.sv
module redsched_top
  import redsched_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 8,
  parameter int CW  = 4,
  parameter int SW  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] inX,
  input  logic        [W-1:0] modP,
  input  logic       [CW-1:0] depCount,
  output logic                busy,
  output logic          [1:0] issueKind,
  output logic          [1:0] issueTag,
  output logic signed [W-1:0] issueOperand,
  output logic                done,
  output logic signed [W-1:0] resultX,
  output logic                reduceOk,
  output logic       [SW-1:0] stallCount
);
  ctrlStrobe_t strb;
  logic        retLast;

  redsched_ctrl #(.LAT(LAT), .CW(CW), .SW(SW)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .depCount  (depCount),
    .retLast   (retLast),
    .strb      (strb),
    .busy      (busy),
    .issueKind (issueKind),
    .issueTag  (issueTag),
    .stallCount(stallCount)
  );

  redsched_data #(.W(W), .LAT(LAT)) uData (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .inX         (inX),
    .modP        (modP),
    .issueOperand(issueOperand),
    .retLast     (retLast),
    .done        (done),
    .resultX     (resultX),
    .reduceOk    (reduceOk)
  );
endmodule

// File: rtl/redsched_chk.sv
module redsched_chk #(
  parameter int W  = 16,
  parameter int SW = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic        [W-1:0] modP,
  input logic                busy,
  input logic          [1:0] issueKind,
  input logic          [1:0] issueTag,
  input logic                done,
  input logic signed [W-1:0] resultX,
  input logic                reduceOk,
  input logic       [SW-1:0] stallCount
);
  AST_CMP_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    (issueKind == 2'd1 && issueTag != 2'd0) |->
      ($past(issueKind) == 2'd1 && $past(issueTag) == issueTag - 2'd1)); // R2

  AST_DEP_AFTER_CMP: assert property (@(posedge clk) disable iff (rst)
    (issueKind == 2'd2) |-> ($past(issueKind) == 2'd1 || $past(issueKind) == 2'd2)); // R4

  AST_NOP_COUNTED: assert property (@(posedge clk) disable iff (rst)
    (issueKind == 2'd3) |=> (stallCount == $past(stallCount) + 1'b1)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (issueKind != 2'd3) |=> $stable(stallCount)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done && reduceOk) |-> (resultX >= 0 && $unsigned(resultX) < modP)); // R3

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R9
endmodule

bind redsched_top redsched_chk #(.W(W), .SW(SW)) uChk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .modP      (modP),
  .busy      (busy),
  .issueKind (issueKind),
  .issueTag  (issueTag),
  .done      (done),
  .resultX   (resultX),
  .reduceOk  (reduceOk),
  .stallCount(stallCount)
);

// File: tb/redsched_top_test.sv
module redsched_top_test;
  localparam int W   = 16;
  localparam int LAT = 8;
  localparam int CW  = 4;
  localparam int SW  = 16;
  localparam int SLOT = LAT - 4;
  localparam int P   = 97;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic signed [W-1:0] inX = '0;
  logic        [W-1:0] modP = W'(P);
  logic       [CW-1:0] depCount = '0;
  logic                busy;
  logic          [1:0] issueKind;
  logic          [1:0] issueTag;
  logic signed [W-1:0] issueOperand;
  logic                done;
  logic signed [W-1:0] resultX;
  logic                reduceOk;
  logic       [SW-1:0] stallCount;

  int nChecks = 0;
  int nFails  = 0;
  int expStall = 0;

  always #10 clk = ~clk;

  redsched_top #(.W(W), .LAT(LAT), .CW(CW), .SW(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .inX(inX), .modP(modP),
    .depCount(depCount), .busy(busy), .issueKind(issueKind),
    .issueTag(issueTag), .issueOperand(issueOperand), .done(done),
    .resultX(resultX), .reduceOk(reduceOk), .stallCount(stallCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refOff(input int k);
    case (k) 0: return 0; 1: return 1; 2: return 2; default: return -1; endcase
  endfunction

  // one reduction; poke!=0 drives a stray start while busy (R9)
  task automatic runReduce(input int xv, input int dv, input bit poke);
    int nDep = (dv > SLOT) ? SLOT : dv;
    int expX = xv;
    bit expOk = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int c = xv - refOff(k) * P;
      if (!expOk && c >= 0 && c < P) begin expX = c; expOk = 1'b1; end
    end
    @(negedge clk);
    inX = W'(xv); depCount = CW'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < LAT; k++) begin
      int ek = (k < 4) ? 1 : (k < 4 + nDep) ? 2 : 3;
      check(int'(issueKind) == ek, (k < 4) ? "R2 kind" : (ek == 2) ? "R4 kind" : "R5 kind",
            int'(issueKind), ek);
      if (k < 4) check(int'(issueTag) == k, "R2 tag", int'(issueTag), k);
      if (ek == 2) check(int'(issueOperand) == xv, "R4 operand", int'(issueOperand), xv);
      if (ek == 3) expStall++;
      if (poke && k == 2) begin start = 1'b1; inX = 16'sd7; depCount = '0; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(int'(issueKind) == 0, "R5 window end", int'(issueKind), 0);
    for (int k = 0; k < 3; k++) begin
      check(done == 1'b0, "R7 early", int'(done), 0);
      @(negedge clk);
    end
    check(done == 1'b0 && busy == 1'b1, "R7 pre-done", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R7 done timing", int'(done), 1);
    check(busy == 1'b0, "R7 busy drop", int'(busy), 0);
    check(int'(resultX) == expX, expOk ? "R3 result" : "R8 result", int'(resultX), expX);
    check(reduceOk == expOk, expOk ? "R3 ok" : "R8 ok", int'(reduceOk), int'(expOk));
    if (expOk) begin
      check(((int'(resultX) - xv) % P) == 0, "R10 congruent", int'(resultX), xv);
      check(int'(resultX) >= 0 && int'(resultX) < P, "R3 range", int'(resultX), 0);
    end
    check(int'(stallCount) == expStall, "R6 stall count", int'(stallCount), expStall);
    @(negedge clk);
    check(done == 1'b0, "R7 single pulse", int'(done), 0);
  endtask

  task automatic testReset();
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'(busy) + int'(done), 0);
    check(int'(stallCount) == 0, "R1 stall", int'(stallCount), 0);
    check(int'(issueKind) == 0, "R1 kind", int'(issueKind), 0);
  endtask

  task automatic testFirstHit();   runReduce(50, 2, 1'b0);   endtask // R3 tag0
  task automatic testSecondHit();  runReduce(150, 4, 1'b0);  endtask // R3 tag1
  task automatic testThirdHit();   runReduce(250, 0, 1'b0);  endtask // R3 tag2
  task automatic testNegative();   runReduce(-30, 1, 1'b0);  endtask // R3 tag3
  task automatic testBoundaries();
    runReduce(0, 3, 1'b0);
    runReduce(96, 4, 1'b0);
    runReduce(97, 2, 1'b0);
    runReduce(-97, 0, 1'b0);
    runReduce(290, 1, 1'b0);
  endtask
  task automatic testNoHit();      runReduce(400, 2, 1'b0);  endtask // R8
  task automatic testDepCap();     runReduce(120, 9, 1'b0);  endtask // R4 cap
  task automatic testBusyStart();  runReduce(200, 1, 1'b1);  endtask // R9

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testFirstHit();
    testSecondHit();
    testThirdHit();
    testNegative();
    testBoundaries();
    testNoHit();
    testDepCap();
    testBusyStart();
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && int'(issueKind) == 0, "R9 no stray run", int'(busy), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule